// File: doc/BRIEF.md
# Coin Accumulating Vending Controller

This block keeps a running sum of inserted coins and raises a one-cycle dispense pulse once that sum reaches the price of an item. A coin is announced by a single-cycle strobe. The coin's value is taken on the following cycle, while the controller is adding. The price is an input that the block compares against the sum on every cycle. After a dispense, the sum goes back to zero so the next purchase starts from nothing.

Inside the block, a control state machine drives a small datapath through two strobes, load and clear. The datapath holds the running sum, an adder that wraps modulo 2^WIDTH, and an unsigned less-than comparator. The comparator's result is the only signal that goes back to the controller. The controller has four states: initialise, wait, add and dispense.

Top module: `vend_accumulator`

## Requirements
- R1: A high `rst` at a rising edge puts the controller in its initialise state. `dispense` is low from then on, and the running sum is zero when the controller next waits, including when reset arrives in the middle of a purchase.
- R2: The initialise state lasts exactly one cycle. It clears the sum and always moves to the wait state.
- R3: In the wait state, a high `coinStrobe` moves the controller to the add state on the next edge. This happens even when the sum already covers the price, so no dispense occurs in that cycle.
- R4: The add state lasts one cycle and always returns to wait. On leaving it, the sum becomes sum + `coinValue`, where `coinValue` is the value present during the add cycle and not the value present during the strobe cycle.
- R5: In the wait state with `coinStrobe` low and sum < `itemCost`, the controller stays in wait and `dispense` stays low.
- R6: In the wait state with `coinStrobe` low and sum >= `itemCost`, the controller enters the dispense state on the next edge. This includes the case where the sum equals the price and the case where the price is 0.
- R7: `dispense` is high only in the dispense state, which lasts one cycle and then goes to initialise. Leftover credit is therefore discarded before the next purchase.
- R8: `coinValue` has no effect while the controller is outside the add state.
- R9: The sum wraps modulo 2^WIDTH. For example, 250 + 10 gives 4 when WIDTH is 8.
- R10: The sum is compared with the price as an unsigned number. For example, a sum of 128 reaches a price of 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| coinStrobe | input | 1 | One-cycle pulse that announces a coin |
| coinValue | input | WIDTH | Coin value, sampled during the add cycle |
| itemCost | input | WIDTH | Price of the item |
| dispense | output | 1 | One-cycle dispense pulse |

## Verification
The bench targets the equality boundary and the one-short boundary. A strict comparison would fail to dispense at exact payment, and an inclusive one would dispense one unit early. It also inserts a coin in the very cycle where the sum already covers the price. A design that ranks the comparison above the strobe would dispense early and lose that coin. The remaining cases are:
- A zero price, where a mistimed initialise state shifts the repeating pulse.
- Wraparound past 2^WIDTH and a sum of 128 against a price of 16, which catch a saturating adder and a signed compare.
- Garbage on `coinValue` outside the add cycle and a reset in the middle of a purchase, which expose leftover or wrongly sampled credit.

// File: rtl/vend_pkg.sv
package vend_pkg;

  typedef enum logic [1:0] {
    ST_INIT = 2'd0,
    ST_WAIT = 2'd1,
    ST_ADD  = 2'd2,
    ST_DISP = 2'd3
  } vendState_e;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic loadTotal;
    logic clearTotal;
  } dpCtrl_t;

endpackage

// File: rtl/vend_datapath.sv
module vend_datapath
  import vend_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  dpCtrl_t          ctrl,
  input  logic [WIDTH-1:0] coinValue,
  input  logic [WIDTH-1:0] itemCost,
  output logic             totalBelowCost
);

  logic [WIDTH-1:0] total;
  logic [WIDTH-1:0] sumNext;

  // Adder wraps modulo 2^WIDTH (R9)
  assign sumNext = total + coinValue;

  always_ff @(posedge clk) begin
    if (rst || ctrl.clearTotal) total <= '0;
    else if (ctrl.loadTotal)    total <= sumNext;
  end

  // Unsigned comparator (R10)
  assign totalBelowCost = (total < itemCost);

  // R8: the sum only moves when a strobe allows it
  assert_total_held_R8: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.loadTotal && !ctrl.clearTotal) |=> $stable(total))
    else $error("total changed without a strobe");

  assert_strobes_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    !(ctrl.loadTotal && ctrl.clearTotal))
    else $error("load and clear together");

endmodule

// File: rtl/vend_control.sv
module vend_control
  import vend_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    coinStrobe,
  input  logic    totalBelowCost,
  output dpCtrl_t ctrl,
  output logic    dispense
);

  vendState_e state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_INIT;
    else     state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctrl      = '0;
    dispense  = 1'b0;
    unique case (state)
      ST_INIT: begin
        ctrl.clearTotal = 1'b1;
        stateNext       = ST_WAIT;
      end
      ST_WAIT: begin
        if (coinStrobe)           stateNext = ST_ADD;
        else if (!totalBelowCost) stateNext = ST_DISP;
      end
      ST_ADD: begin
        ctrl.loadTotal = 1'b1;
        stateNext      = ST_WAIT;
      end
      ST_DISP: begin
        dispense  = 1'b1;
        stateNext = ST_INIT;
      end
      default: stateNext = ST_INIT;
    endcase
  end

  assert_init_to_wait_R2: assert property (@(posedge clk) disable iff (rst)
    state == ST_INIT |=> state == ST_WAIT) else $error("init did not advance");

  assert_coin_first_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && coinStrobe) |=> state == ST_ADD) else $error("coin not taken");

  assert_add_returns_R4: assert property (@(posedge clk) disable iff (rst)
    state == ST_ADD |=> state == ST_WAIT) else $error("add did not return");

  assert_hold_short_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !coinStrobe && totalBelowCost) |=> state == ST_WAIT)
    else $error("left wait while short");

  assert_paid_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !coinStrobe && !totalBelowCost) |=> state == ST_DISP)
    else $error("no dispense when paid");

  assert_pulse_once_R7: assert property (@(posedge clk) disable iff (rst)
    dispense |=> (!dispense && state == ST_INIT)) else $error("dispense not one cycle");

endmodule

// File: rtl/vend_accumulator.sv
module vend_accumulator
  import vend_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             coinStrobe,
  input  logic [WIDTH-1:0] coinValue,
  input  logic [WIDTH-1:0] itemCost,
  output logic             dispense
);

  dpCtrl_t dpCtrl;
  logic    totalBelowCost;

  vend_control ctrl_i (
    .clk            (clk),
    .rst            (rst),
    .coinStrobe     (coinStrobe),
    .totalBelowCost (totalBelowCost),
    .ctrl           (dpCtrl),
    .dispense       (dispense)
  );

  vend_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk            (clk),
    .rst            (rst),
    .ctrl           (dpCtrl),
    .coinValue      (coinValue),
    .itemCost       (itemCost),
    .totalBelowCost (totalBelowCost)
  );

endmodule

// File: tb/vend_accumulator_tb_top.sv
`timescale 1ns/1ps
module vend_accumulator_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       coinStrobe = 1'b0;
  logic [7:0] coinValue = 8'h00;
  logic [7:0] itemCost = 8'd50;
  logic       dispense;
  int         testsRun = 0;
  int         testsFailed = 0;
  bit         finished = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  vend_accumulator #(.WIDTH(8)) dut_i (
    .clk(clk), .rst(rst), .coinStrobe(coinStrobe),
    .coinValue(coinValue), .itemCost(itemCost), .dispense(dispense)
  );

  task automatic check(input logic got, input logic exp, input string req);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s: dispense=%0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  // Ends at a falling edge with the controller in wait
  task automatic doReset(input logic [7:0] cost);
    @(negedge clk);
    rst = 1'b1; coinStrobe = 1'b0; itemCost = cost;
    @(negedge clk);
    check(dispense, 1'b0, "R1");
    rst = 1'b0;
    @(negedge clk);
  endtask

  // Garbage on coinValue in the strobe cycle and afterwards (R4, R8)
  task automatic insertCoin(input logic [7:0] v);
    coinStrobe = 1'b1; coinValue = ~v;
    @(negedge clk);
    coinStrobe = 1'b0; coinValue = v;
    @(negedge clk);
    coinValue = 8'hC3;
  endtask

  task automatic expectIdle(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(dispense, 1'b0, req);
    end
  endtask

  task automatic expectDispense(input string req);
    @(negedge clk);
    check(dispense, 1'b1, req);
    @(negedge clk);
    check(dispense, 1'b0, "R7");
    @(negedge clk);
  endtask

  task automatic testExactPay();
    doReset(8'd50);
    expectIdle(3, "R5");
    insertCoin(8'd25);
    expectIdle(3, "R5");
    insertCoin(8'd25);
    expectDispense("R6");
  endtask

  task automatic testOneShortAndClear();
    itemCost = 8'd40;       // leftover must be gone (R7)
    expectIdle(2, "R7");
    insertCoin(8'd39);
    expectIdle(3, "R5");
    insertCoin(8'd1);
    expectDispense("R6");
  endtask

  task automatic testCoinPriority();
    doReset(8'd20);
    insertCoin(8'd20);
    coinStrobe = 1'b1; coinValue = 8'h00;
    @(negedge clk);
    check(dispense, 1'b0, "R3");
    coinStrobe = 1'b0; coinValue = 8'd5;
    @(negedge clk);
    check(dispense, 1'b0, "R4");
    coinValue = 8'h77;
    expectDispense("R6");
  endtask

  task automatic testValueIgnored();
    doReset(8'd60);
    coinValue = 8'd200;
    expectIdle(3, "R8");
    insertCoin(8'd30);
    coinValue = 8'd90;
    expectIdle(3, "R8");
    insertCoin(8'd30);
    expectDispense("R4");
  endtask

  task automatic testZeroCost();
    doReset(8'd0);
    // Init then wait then dispense: period of three cycles (R2)
    expectDispense("R2");
    expectDispense("R6");
    itemCost = 8'd50;
  endtask

  task automatic testWrap();
    doReset(8'd255);
    insertCoin(8'd250);
    expectIdle(2, "R5");
    insertCoin(8'd10);      // 260 wraps to 4
    expectIdle(3, "R9");
    insertCoin(8'd251);     // 255
    expectDispense("R9");
  endtask

  task automatic testUnsigned();
    doReset(8'h10);
    insertCoin(8'h80);
    expectDispense("R10");
  endtask

  task automatic testMidReset();
    doReset(8'd100);
    insertCoin(8'd60);
    doReset(8'd100);
    insertCoin(8'd60);
    expectIdle(3, "R1");
    insertCoin(8'd40);
    expectDispense("R1");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(dispense, 1'b0, "R1");
    testExactPay();
    testOneShortAndClear();
    testCoinPriority();
    testValueIgnored();
    testZeroCost();
    testWrap();
    testUnsigned();
    testMidReset();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: run incomplete, expected end of tests");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule